// File: doc/BRIEF.md
# CAS-before-RAS Refresh Scheduler

This block keeps an asynchronous DRAM refreshed and brings it up after power-on. It measures time in clock cycles, derived from a clock-frequency parameter and nanosecond timing parameters. When a refresh is owed, it raises a request to the access controller. Once the controller grants, the block takes the strobe lines. It runs one or more refresh cycles in which the column strobe falls before the row strobe, then signals completion with a one-cycle pulse. The DRAM keeps its own row counter, so no address is driven.

After reset, the block waits out a power-up pause. It then asks for a burst of initialization refresh cycles, and `ready` tells the controller when normal access may begin. If the controller is slow to grant, missed intervals become a debt. The debt is capped by a parameter, and the owed cycles run back to back at the next grant. A low-power parameter doubles the refresh interval.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While reset is asserted, `ras_n`, `cas_n` and `we_n` are high, and `ref_req`, `ref_done` and `ready` are low.
- R2: `ref_req` stays low for the first N_PAUSE clock edges after reset, where N_PAUSE = max(1, ceil(PAUSE_NS*CLK_MHZ/1000)). It rises right after edge N_PAUSE.
- R3: The first grant after the pause runs exactly INIT_CYCLES refresh cycles back to back. `ready` is low until the edge that ends the last of them, rises there, and then stays high.
- R4: Each refresh cycle follows a fixed order. Counted from the grant edge, there are N_PRE cycles with both strobes high, then N_CSR cycles with `cas_n` low and `ras_n` high, then N_RASL cycles with `ras_n` low. During those, `cas_n` is low for the first N_CHR cycles and high for the rest. Here N_RASL = max(N_RAS, N_CHR) and N_PRE = max(N_RP-N_CSR, N_RPC, N_RC-N_RASL-N_CSR, 1). Each N_x is the ns parameter rounded up to cycles, with a minimum of one.
- R5: `we_n` is high at all times, so it is high around every falling edge of `ras_n`.
- R6: `ref_done` is a single-cycle pulse. It is high in the cycle after the last refresh cycle of a burst, and both strobes are high in that cycle.
- R7: Once `ready` is high, one refresh is owed every N_INT cycles, with the first N_INT edges after `ready` rises. The owed count saturates at DEBT_MAX. `ref_req` is high exactly when refreshes are owed and no burst runs. One grant pays the whole debt, including any that accrues during the burst.
- R8: With LOW_POWER = 1, N_INT is computed from twice PERIOD_NS.
- R9: `ref_gnt` has no effect while `ref_req` is low. The strobes stay high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Grant from the access controller, sampled while `ref_req` is high |
| ref_req | output | 1 | Refresh owed, requesting the strobe lines |
| ref_done | output | 1 | One-cycle pulse after a burst ends |
| ready | output | 1 | Power-up pause and initialization complete |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |

## Verification
The hardest case to reach is a saturated debt that is paid without a fresh interval tick landing inside the burst. A tick inside the burst would lengthen it and hide the cap. The stimulus first grants continuously so that every tick is served at once. It then withholds the grant for a fixed count measured from a `ref_done`, long enough for more ticks than DEBT_MAX to pass. Finally it grants for one cycle early enough that the whole capped burst ends before the next tick. A second instance with the low-power setting shares the same grant and is checked against its own model.

// File: rtl/cbr_refresh_pkg.sv
package cbr_refresh_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_PRE,
        PH_SETUP,
        PH_STROBE
    } ph_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // nanoseconds to whole clock cycles, rounded up, never below one
    function automatic int ns_to_cyc(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/cbr_refresh_timer.sv
module cbr_refresh_timer #(
    parameter int N_PAUSE = 50000,
    parameter int N_INT   = 3907
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic pause_hit,
    output logic int_hit
);
    localparam int CW = $clog2(cbr_refresh_pkg::imax(N_PAUSE, N_INT) + 1);

    typedef struct packed {
        logic          pausing;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d         = q;
        pause_hit = 1'b0;
        int_hit   = 1'b0;
        if (q.pausing) begin
            if (q.cnt == CW'(N_PAUSE - 1)) begin
                pause_hit = 1'b1;
                d.pausing = 1'b0;
                d.cnt     = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else if (run) begin
            if (q.cnt == CW'(N_INT - 1)) begin
                int_hit = 1'b1;
                d.cnt   = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.pausing <= 1'b1;
            q.cnt     <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/cbr_refresh_debt.sv
module cbr_refresh_debt #(
    parameter int MAXV  = 8,
    parameter int INITV = 8,
    parameter int DW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_init,
    input  logic          inc,
    input  logic          dec,
    output logic [DW-1:0] owed,
    output logic          nonzero
);
    logic [DW-1:0] owed_q, owed_d, after_dec;

    always_comb begin
        after_dec = owed_q - DW'(dec);
        if (load_init) begin
            owed_d = DW'(INITV);
        end else if (inc && (after_dec < DW'(MAXV))) begin
            owed_d = after_dec + 1'b1;
        end else begin
            owed_d = after_dec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) owed_q <= '0;
        else        owed_q <= owed_d;
    end

    assign owed    = owed_q;
    assign nonzero = (owed_q != '0);
endmodule

// File: rtl/cbr_refresh_strobe.sv
module cbr_refresh_strobe
    import cbr_refresh_pkg::*;
#(
    parameter int N_PRE  = 6,
    parameter int N_CSR  = 2,
    parameter int N_CHR  = 2,
    parameter int N_RASL = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic cyc_end,
    output logic ras_n,
    output logic cas_n
);
    localparam int CW = $clog2(imax(imax(N_PRE, N_CSR), imax(N_CHR, N_RASL)) + 1);

    typedef struct packed {
        ph_e           ph;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d       = q;
        cyc_end = 1'b0;
        case (q.ph)
            PH_PRE: begin
                if (q.cnt == CW'(N_PRE - 1)) begin
                    d.ph  = PH_SETUP;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            PH_SETUP: begin
                if (q.cnt == CW'(N_CSR - 1)) begin
                    d.ph  = PH_STROBE;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            PH_STROBE: begin
                if (q.cnt == CW'(N_RASL - 1)) begin
                    cyc_end = 1'b1;
                    d.ph    = PH_IDLE;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: begin
                d.cnt = '0;
            end
        endcase
        if (start) begin
            d.ph  = PH_PRE;
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.ph  <= PH_IDLE;
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign ras_n = (q.ph != PH_STROBE);
    assign cas_n = !((q.ph == PH_SETUP) ||
                     ((q.ph == PH_STROBE) && (q.cnt < CW'(N_CHR))));
endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched
    import cbr_refresh_pkg::*;
#(
    parameter int CLK_MHZ     = 250,
    parameter bit LOW_POWER   = 1'b0,
    parameter int PAUSE_NS    = 200000,
    parameter int PERIOD_NS   = 15625,
    parameter int INIT_CYCLES = 8,
    parameter int DEBT_MAX    = 8,
    parameter int T_CSR_NS    = 5,
    parameter int T_CHR_NS    = 8,
    parameter int T_RP_NS     = 30,
    parameter int T_RPC_NS    = 5,
    parameter int T_RAS_NS    = 50,
    parameter int T_RC_NS     = 84
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_gnt,
    output logic ref_req,
    output logic ref_done,
    output logic ready,
    output logic ras_n,
    output logic cas_n,
    output logic we_n
);
    localparam int N_PAUSE = ns_to_cyc(PAUSE_NS, CLK_MHZ);
    localparam int N_INT   = ns_to_cyc(PERIOD_NS * (LOW_POWER ? 2 : 1), CLK_MHZ);
    localparam int N_CSR   = ns_to_cyc(T_CSR_NS, CLK_MHZ);
    localparam int N_CHR   = ns_to_cyc(T_CHR_NS, CLK_MHZ);
    localparam int N_RP    = ns_to_cyc(T_RP_NS, CLK_MHZ);
    localparam int N_RPC   = ns_to_cyc(T_RPC_NS, CLK_MHZ);
    localparam int N_RAS   = ns_to_cyc(T_RAS_NS, CLK_MHZ);
    localparam int N_RC    = ns_to_cyc(T_RC_NS, CLK_MHZ);
    localparam int N_RASL  = imax(N_RAS, N_CHR);
    localparam int N_PRE   = imax(imax(N_RP - N_CSR, N_RPC),
                                  imax(N_RC - N_RASL - N_CSR, 1));
    localparam int DW      = $clog2(imax(DEBT_MAX, INIT_CYCLES) + 1);

    typedef struct packed {
        logic busy;
        logic init;
        logic rdy;
        logic done;
    } ctl_t;

    ctl_t q, d;

    logic          pause_hit, int_hit;
    logic          start, cyc_end, owed_nz;
    logic [DW-1:0] owed;

    cbr_refresh_timer #(
        .N_PAUSE (N_PAUSE),
        .N_INT   (N_INT)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (q.rdy),
        .pause_hit (pause_hit),
        .int_hit   (int_hit)
    );

    cbr_refresh_debt #(
        .MAXV  (DEBT_MAX),
        .INITV (INIT_CYCLES),
        .DW    (DW)
    ) u_debt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_init (pause_hit),
        .inc       (int_hit),
        .dec       (start),
        .owed      (owed),
        .nonzero   (owed_nz)
    );

    cbr_refresh_strobe #(
        .N_PRE  (N_PRE),
        .N_CSR  (N_CSR),
        .N_CHR  (N_CHR),
        .N_RASL (N_RASL)
    ) u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .cyc_end (cyc_end),
        .ras_n   (ras_n),
        .cas_n   (cas_n)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        start  = 1'b0;
        if (!q.busy) begin
            if (owed_nz && ref_gnt) begin
                start  = 1'b1;
                d.busy = 1'b1;
            end
        end else if (cyc_end) begin
            if (owed_nz) begin
                start = 1'b1;
            end else begin
                d.busy = 1'b0;
                d.done = 1'b1;
                if (q.init) begin
                    d.rdy  = 1'b1;
                    d.init = 1'b0;
                end
            end
        end
        if (pause_hit) begin
            d.init = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ref_req  = !q.busy && owed_nz;
    assign ref_done = q.done;
    assign ready    = q.rdy;
    assign we_n     = 1'b1;

    logic unused_owed;
    assign unused_owed = ^owed;
endmodule

// File: rtl/cbr_refresh_sched_chk.sv
module cbr_refresh_sched_chk (
    input logic clk,
    input logic rst_n,
    input logic ref_gnt,
    input logic ref_req,
    input logic ref_done,
    input logic ready,
    input logic ras_n,
    input logic cas_n
);
    // R4: column strobe already low in the cycle before the row strobe falls
    p_cas_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)))
        else $error("cas_n not low ahead of ras_n fall");

    // R4: column strobe is high when the row strobe rises
    p_cas_high_at_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> cas_n)
        else $error("cas_n low at ras_n rise");

    // R6: done is one cycle long with the bus released
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_done |-> (ras_n && cas_n) ##1 !ref_done)
        else $error("done pulse malformed");

    // R3: ready never drops once raised
    p_ready_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready)
        else $error("ready dropped");

    // R7: a request without a grant persists
    p_req_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_gnt) |=> ref_req)
        else $error("request withdrawn without grant");

    // R9: strobes idle while requesting
    p_req_idle_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> (ras_n && cas_n))
        else $error("strobes active while requesting");
endmodule

bind cbr_refresh_sched cbr_refresh_sched_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_gnt  (ref_gnt),
    .ref_req  (ref_req),
    .ref_done (ref_done),
    .ready    (ready),
    .ras_n    (ras_n),
    .cas_n    (cas_n)
);

// File: tb/cbr_refresh_sched_tb.sv
`timescale 1ns/1ps

module cbr_refresh_model #(
    parameter int N_PAUSE = 500,
    parameter int N_INT   = 100,
    parameter int N_PRE   = 6,
    parameter int N_CSR   = 2,
    parameter int N_CHR   = 2,
    parameter int N_RASL  = 13,
    parameter int INIT    = 8,
    parameter int DMAX    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gnt,
    output logic e_req,
    output logic e_done,
    output logic e_ready,
    output logic e_ras_n,
    output logic e_cas_n
);
    int t, t_ready, owed, pos;
    bit busy, init, tick;
    localparam int L = N_PRE + N_CSR + N_RASL;

    always @(posedge clk) begin
        if (!rst_n) begin
            t = 0; t_ready = 0; owed = 0; pos = 0;
            busy = 0; init = 0; e_ready = 0; e_done = 0;
        end else begin
            t = t + 1;
            e_done = 0;
            tick = e_ready && (((t - t_ready) % N_INT) == 0);
            if (busy) begin
                pos = pos + 1;
                if (pos == L) begin
                    if (owed > 0) begin
                        owed = owed - 1;
                        pos = 0;
                    end else begin
                        busy = 0;
                        e_done = 1;
                        if (init) begin
                            e_ready = 1;
                            t_ready = t;
                            init = 0;
                        end
                    end
                end
            end else if (owed > 0 && gnt) begin
                busy = 1;
                pos = 0;
                owed = owed - 1;
            end
            if (t == N_PAUSE) begin
                owed = INIT;
                init = 1;
            end
            if (tick && owed < DMAX) owed = owed + 1;
        end
        e_req   = !busy && owed > 0;
        e_ras_n = !(busy && pos >= N_PRE + N_CSR);
        e_cas_n = !(busy && pos >= N_PRE && pos < N_PRE + N_CSR + N_CHR);
    end
endmodule

module cbr_refresh_sched_tb;
    localparam int MHZ   = 250;
    localparam int PAUSE = 2000;
    localparam int PER   = 400;
    localparam int INITC = 8;
    localparam int DMAX  = 3;

    function automatic int cyc(input int ns);
        int c;
        c = (ns * MHZ + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_CSR  = cyc(5);
    localparam int E_CHR  = cyc(8);
    localparam int E_RASL = mx(cyc(50), E_CHR);
    localparam int E_PRE  = mx(mx(cyc(30) - E_CSR, cyc(5)), mx(cyc(84) - E_RASL - E_CSR, 1));

    logic clk = 0, rst_n = 0, gnt = 0;
    always #2 clk = ~clk;

    logic req, done, rdy, ras_n, cas_n, we_n;
    logic req2, done2, rdy2, ras2, cas2, we2;
    logic x_req, x_done, x_rdy, x_ras, x_cas;
    logic y_req, y_done, y_rdy, y_ras, y_cas;

    cbr_refresh_sched #(.CLK_MHZ(MHZ), .LOW_POWER(1'b0), .PAUSE_NS(PAUSE),
        .PERIOD_NS(PER), .INIT_CYCLES(INITC), .DEBT_MAX(DMAX)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_gnt(gnt), .ref_req(req), .ref_done(done),
        .ready(rdy), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n));

    cbr_refresh_sched #(.CLK_MHZ(MHZ), .LOW_POWER(1'b1), .PAUSE_NS(PAUSE),
        .PERIOD_NS(PER), .INIT_CYCLES(INITC), .DEBT_MAX(DMAX)) u_dut_lp (
        .clk(clk), .rst_n(rst_n), .ref_gnt(gnt), .ref_req(req2), .ref_done(done2),
        .ready(rdy2), .ras_n(ras2), .cas_n(cas2), .we_n(we2));

    cbr_refresh_model #(.N_PAUSE(cyc(PAUSE)), .N_INT(cyc(PER)), .N_PRE(E_PRE),
        .N_CSR(E_CSR), .N_CHR(E_CHR), .N_RASL(E_RASL), .INIT(INITC), .DMAX(DMAX)) u_ref (
        .clk(clk), .rst_n(rst_n), .gnt(gnt), .e_req(x_req), .e_done(x_done),
        .e_ready(x_rdy), .e_ras_n(x_ras), .e_cas_n(x_cas));

    cbr_refresh_model #(.N_PAUSE(cyc(PAUSE)), .N_INT(cyc(2 * PER)), .N_PRE(E_PRE),
        .N_CSR(E_CSR), .N_CHR(E_CHR), .N_RASL(E_RASL), .INIT(INITC), .DMAX(DMAX)) u_ref_lp (
        .clk(clk), .rst_n(rst_n), .gnt(gnt), .e_req(y_req), .e_done(y_done),
        .e_ready(y_rdy), .e_ras_n(y_ras), .e_cas_n(y_cas));

    int n_cmp = 0, n_bad = 0;
    int ras_falls = 0, init_falls = 0;
    logic prev_ras = 1'b1;
    bit finished = 0;

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // per-clock comparison, sampled 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            chk(ras_n, x_ras, "R4", "ras_n");
            chk(cas_n, x_cas, "R4", "cas_n");
            chk(we_n, 1'b1, "R5", "we_n");
            chk(req, x_req, x_rdy ? "R7" : "R2", "ref_req");
            chk(done, x_done, "R6", "ref_done");
            chk(rdy, x_rdy, "R3", "ready");
            chk(ras2, y_ras, "R8", "lp ras_n");
            chk(cas2, y_cas, "R8", "lp cas_n");
            chk(req2, y_req, "R8", "lp ref_req");
            chk(done2, y_done, "R8", "lp ref_done");
            chk(rdy2, y_rdy, "R8", "lp ready");
            if (prev_ras && !ras_n) begin
                ras_falls++;
                if (!rdy) init_falls++;
            end
            prev_ras = ras_n;
        end
    end

    initial begin
        for (int k = 0; k < 20000; k++) @(negedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int snap;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(ras_n, 1'b1, "R1", "ras_n in reset");
        chk(cas_n, 1'b1, "R1", "cas_n in reset");
        chk(we_n, 1'b1, "R1", "we_n in reset");
        chk(req, 1'b0, "R1", "ref_req in reset");
        chk(done, 1'b0, "R1", "ref_done in reset");
        chk(rdy, 1'b0, "R1", "ready in reset");
        rst_n = 1;
        repeat (100) @(negedge clk);
        // R9: grant while nothing is requested
        gnt = 1;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            chk(ras_n & cas_n, 1'b1, "R9", "strobes under unrequested grant");
        end
        gnt = 0;
        repeat (400) @(negedge clk);
        chk(req, 1'b1, "R2", "init request pending");
        gnt = 1;
        while (!rdy) @(negedge clk);
        n_cmp++;
        if (init_falls != INITC) begin
            n_bad++;
            $display("FAIL R3 init cycles: actual=%0d expected=%0d", init_falls, INITC);
        end
        repeat (450) @(negedge clk);
        while (!done) @(negedge clk);
        gnt = 0;
        repeat (390) @(negedge clk);
        chk(req, 1'b1, "R7", "debt pending");
        snap = ras_falls;
        gnt = 1;
        @(negedge clk);
        gnt = 0;
        while (!done) @(negedge clk);
        n_cmp++;
        if (ras_falls - snap != DMAX) begin
            n_bad++;
            $display("FAIL R7 capped burst: actual=%0d expected=%0d", ras_falls - snap, DMAX);
        end
        gnt = 1;
        repeat (800) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule